// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block guards bus cycles that the local processor launches toward the external bus. When such a cycle opens, the block counts system clocks until the target returns its data-and-size acknowledge. If the count reaches a limit chosen by a 2-bit period select before that happens, the block raises a bus error pulse. The processor's exception logic then takes over. Cycles driven by any other bus master are never timed, because a separate monitor must look after those.

A word transfer to an 8-bit port is made of two byte accesses. The block treats these as one transaction. The first byte's acknowledge does not restart the count, and the window closes only on the second acknowledge. For this reason the selected period must be at least twice the clock count of one byte access. The period select and the transfer shape are captured when a window opens. While a window is open, the strobe, the width pins and the select are not looked at. The block has no data path and no back-pressure. All pins are plain level or strobe controls, sampled on the rising clock edge.

Top module: `bus_cycle_timeout_monitor`

## Requirements
- R1: While reset is held and after it is released, `bus_error` is low until a window expires.
- R2: The period select is latched when a window opens, with 11 = 8, 10 = 16, 01 = 32 and 00 = 64 clocks. If the window is not closed, `bus_error` is high in the cycle after the N-th rising edge that follows the edge sampling the opening strobe, where N is the selected period.
- R3: An expiry gives a `bus_error` pulse exactly one clock long. The block then stays idle and raises nothing more until a new window opens.
- R4: While `mon_enable` is low, no window opens and no error is raised. Dropping `mon_enable` during an open window abandons it silently.
- R5: A window opens only when `cycle_start` and `cpu_owner` are both high on the same edge. A strobe with `cpu_owner` low is ignored.
- R6: The closing acknowledge is sampled from the first edge after the opening edge. If it arrives on or before the expiry edge, it closes the window with no error, and it wins a tie with expiry.
- R7: When `narrow_port` = 1 and `word_xfer` = 1 at the opening edge, two acknowledges are needed. The first one does not clear the count. If the second one is missing, the expiry time is the same as for a single access. Any other combination closes on the first acknowledge.
- R8: A change of `period_sel` while a window is open does not move that window's expiry.
- R9: A `cycle_start` strobe while a window is open neither restarts nor extends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_enable | input | 1 | Monitor enable; low disables all timing |
| period_sel | input | 2 | Timeout period select, latched at window open |
| cycle_start | input | 1 | One-clock strobe marking the start of a bus cycle |
| cpu_owner | input | 1 | High when the local processor owns the cycle |
| narrow_port | input | 1 | Target port is 8 bits wide |
| word_xfer | input | 1 | Transfer is a 16-bit word |
| ack | input | 1 | Data-and-size acknowledge from the target |
| bus_error | output | 1 | One-clock bus error pulse on timeout |

## Verification
The checker checks on every clock that the error pulse lasts one cycle. It also checks that the pulse follows an enabled open window, that a closing acknowledge always suppresses an error, that the count stays under the latched limit, and that the limit holds still while a window is open. Exact expiry times for each period code need the bench's scenarios, as do the two-acknowledge handling of a word to an 8-bit port, and the immunity to ownerless strobes, mid-window strobes and mid-window select changes. The bench's reference model follows these at every clock.

// File: rtl/bto_pkg.sv
package bto_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_TIMING = 1'b1
  } win_state_t;

  // Number of acknowledges a window needs before it closes.
  typedef logic [1:0] beat_cnt_t;

  function automatic beat_cnt_t beats_for(input logic narrow, input logic word);
    beat_cnt_t b;
    b = (narrow && word) ? 2'd2 : 2'd1;
    return b;
  endfunction

endpackage

// File: rtl/bto_limit_sel.sv
// Turns the 2-bit period select into a clock count: the base count scaled by
// a power of two; code 3 is the shortest window, code 0 the longest.
module bto_limit_sel #(
  parameter int BASE_TICKS = 8,
  parameter int LIM_W      = 7
) (
  input  logic [1:0]       sel,
  output logic [LIM_W-1:0] limit
);
  localparam int NCODES = 4;

  logic [LIM_W-1:0] table_q [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_codes
    assign table_q[g] = LIM_W'(BASE_TICKS << (NCODES - 1 - g));
  end

  assign limit = table_q[sel];
endmodule

// File: rtl/bto_beat_track.sv
// Tracks how many acknowledges the open window still needs.
module bto_beat_track
  import bto_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  beat_cnt_t load_val,
  input  logic      consume,
  input  logic      clear,
  output logic      last_beat
);
  beat_cnt_t left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (load)    left_q <= load_val;
    else if (clear)   left_q <= '0;
    else if (consume) left_q <= left_q - beat_cnt_t'(1);
  end

  assign last_beat = (left_q == beat_cnt_t'(1));
endmodule

// File: rtl/bto_tick_counter.sv
// Counts clocks of an open window; flags the clock on which the latched limit
// would be reached.
module bto_tick_counter #(
  parameter int CNT_W = 6,
  parameter int LIM_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LIM_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= count + CNT_W'(1);
  end

  assign at_limit = ({1'b0, count} == (limit - LIM_W'(1)));
endmodule

// File: rtl/bus_cycle_timeout_monitor.sv
module bus_cycle_timeout_monitor
  import bto_pkg::*;
#(
  parameter int BASE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mon_enable,
  input  logic [1:0] period_sel,
  input  logic       cycle_start,
  input  logic       cpu_owner,
  input  logic       narrow_port,
  input  logic       word_xfer,
  input  logic       ack,
  output logic       bus_error
);
  localparam int MAX_TICKS = BASE_TICKS * 8;
  localparam int CNT_W     = $clog2(MAX_TICKS);
  localparam int LIM_W     = CNT_W + 1;

  win_state_t       state_q;
  logic [LIM_W-1:0] limit_sel;
  logic [LIM_W-1:0] limit_q;
  logic [CNT_W-1:0] tick_count;
  logic             at_limit;
  logic             last_beat;
  logic             win_active;
  logic             open_win;
  logic             finish;
  logic             expire;
  logic             leave;
  logic             err_q;

  assign win_active = (state_q == ST_TIMING);
  assign open_win   = !win_active && mon_enable && cycle_start && cpu_owner;
  assign finish     = win_active && mon_enable && ack && last_beat;
  assign expire     = win_active && mon_enable && !finish && at_limit;
  assign leave      = win_active && (!mon_enable || finish || expire);

  bto_limit_sel #(.BASE_TICKS(BASE_TICKS), .LIM_W(LIM_W)) u_lim (
    .sel   (period_sel),
    .limit (limit_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        limit_q <= LIM_W'(MAX_TICKS);
    else if (open_win) limit_q <= limit_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (open_win) state_q <= ST_TIMING;
    else if (leave)    state_q <= ST_IDLE;
  end

  bto_tick_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (open_win || leave),
    .step     (win_active),
    .limit    (limit_q),
    .count    (tick_count),
    .at_limit (at_limit)
  );

  bto_beat_track u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (open_win),
    .load_val  (beats_for(narrow_port, word_xfer)),
    .consume   (win_active && mon_enable && ack && !last_beat),
    .clear     (leave),
    .last_beat (last_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= expire;
  end

  assign bus_error = err_q;
endmodule

// File: rtl/bto_checker.sv
module bto_checker #(
  parameter int CNT_W = 6,
  parameter int LIM_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mon_enable,
  input logic             ack,
  input logic             bus_error,
  input logic             active,
  input logic             last_beat,
  input logic [CNT_W-1:0] count,
  input logic [LIM_W-1:0] limit
);
  // R3: the error is a single-clock pulse
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_error |=> !bus_error);

  // R4: an error only follows an enabled, open window
  assert_err_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_error |-> ($past(mon_enable) && $past(active)));

  // R6: a closing acknowledge never yields an error
  assert_ack_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mon_enable && ack && last_beat) |=> !bus_error);

  // R2: the count never reaches the latched limit
  assert_count_below_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ({1'b0, count} < limit));

  // R8: the limit is frozen while a window stays open
  assert_limit_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(limit));

  // R3: an idle block holds a zero count
  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (count == '0));
endmodule

bind bus_cycle_timeout_monitor bto_checker #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mon_enable (mon_enable),
  .ack        (ack),
  .bus_error  (bus_error),
  .active     (win_active),
  .last_beat  (last_beat),
  .count      (tick_count),
  .limit      (limit_q)
);

// File: tb/bus_cycle_timeout_monitor_test.sv
`timescale 1ns/1ps
module bus_cycle_timeout_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_enable = 1'b0;
  logic [1:0] period_sel = 2'b11;
  logic cycle_start = 1'b0, cpu_owner = 1'b0, narrow_port = 1'b0, word_xfer = 1'b0, ack = 1'b0;
  logic bus_error;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  bus_cycle_timeout_monitor uut (
    .clk(clk), .rst_n(rst_n), .mon_enable(mon_enable), .period_sel(period_sel),
    .cycle_start(cycle_start), .cpu_owner(cpu_owner), .narrow_port(narrow_port),
    .word_xfer(word_xfer), .ack(ack), .bus_error(bus_error)
  );

  // Behavioural reference model
  bit m_act = 0, m_err = 0;
  int m_cnt = 0, m_lim = 64, m_left = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_err = 0; m_cnt = 0; m_left = 0;
    end else begin
      m_err = 0;
      if (m_act) begin
        if (!mon_enable) m_act = 0;
        else if (ack && m_left == 1) m_act = 0;
        else begin
          if (ack) m_left--;
          if (m_cnt == m_lim - 1) begin m_err = 1; m_act = 0; end
          else m_cnt++;
        end
        if (!m_act) m_cnt = 0;
      end else if (cycle_start && cpu_owner && mon_enable) begin
        m_act = 1; m_cnt = 0; m_lim = 64 >> period_sel;
        m_left = (narrow_port && word_xfer) ? 2 : 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) check(bus_error === m_err, cur_req, int'(bus_error), int'(m_err));
  end

  // Open a window at the next negedge (sampled at edge E0), then release the strobe.
  task automatic start_win(input logic [1:0] sel, input bit nar, input bit wrd, input bit own);
    @(negedge clk);
    period_sel = sel; narrow_port = nar; word_xfer = wrd; cpu_owner = own; cycle_start = 1;
    @(negedge clk);
    cycle_start = 0;
  endtask

  // Called right after start_win (at negedge n1): count negedges until bus_error seen.
  task automatic measure(output int k, input int max_n);
    k = 0;
    for (int i = 2; i <= max_n; i++) begin
      @(negedge clk);
      if (bus_error === 1'b1 && k == 0) k = i;
    end
  endtask

  // From negedge n1, drive ack at negedge n_j (sampled at edge E_j).
  task automatic ack_at(input int j, inout int now);
    while (now < j) begin @(negedge clk); now++; end
    ack = 1;
    @(negedge clk); now++;
    ack = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int k, now, hits;

  initial begin
    #(5.0 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    check(bus_error === 1'b0, "R1 during reset", int'(bus_error), 0);
    rst_n = 1; mon_enable = 1;
    idle(2);
    check(bus_error === 1'b0, "R1 after reset", int'(bus_error), 0);

    // R2 / R3: every period code, expiry seen at negedge n_(N+1)
    for (int s = 0; s < 4; s++) begin
      cur_req = "R2";
      start_win(2'(s), 0, 0, 1);
      measure(k, (64 >> s) + 1);
      check(k == (64 >> s) + 1, "R2 expiry time", k, (64 >> s) + 1);
      cur_req = "R3";
      @(negedge clk);
      check(bus_error === 1'b0, "R3 pulse width", int'(bus_error), 0);
      hits = 0;
      for (int i = 0; i < 70; i++) begin @(negedge clk); if (bus_error) hits++; end
      check(hits == 0, "R3 stays idle", hits, 0);
    end

    // R6: ack exactly on expiry edge, and early ack
    cur_req = "R6";
    start_win(2'b11, 0, 0, 1); now = 1; ack_at(8, now);
    hits = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (bus_error) hits++; end
    check(hits == 0, "R6 ack on expiry edge wins", hits, 0);
    start_win(2'b10, 0, 0, 1); now = 1; ack_at(3, now);
    hits = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (bus_error) hits++; end
    check(hits == 0, "R6 early ack", hits, 0);

    // R4: disabled monitor, and disable mid-window
    cur_req = "R4";
    mon_enable = 0;
    start_win(2'b11, 0, 0, 1);
    hits = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (bus_error) hits++; end
    check(hits == 0, "R4 disabled no error", hits, 0);
    mon_enable = 1;
    start_win(2'b11, 0, 0, 1);
    idle(3); mon_enable = 0; idle(1); mon_enable = 1;
    hits = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (bus_error) hits++; end
    check(hits == 0, "R4 abandon mid-window", hits, 0);

    // R5: foreign master cycle ignored
    cur_req = "R5";
    start_win(2'b11, 0, 0, 0);
    hits = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (bus_error) hits++; end
    check(hits == 0, "R5 non-owner strobe ignored", hits, 0);

    // R7: word to 8-bit port, period 16, bytes of 7 clocks
    cur_req = "R7";
    start_win(2'b10, 1, 1, 1); now = 1; ack_at(7, now); ack_at(14, now);
    hits = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (bus_error) hits++; end
    check(hits == 0, "R7 two acks close window", hits, 0);
    start_win(2'b10, 1, 1, 1); now = 1; ack_at(7, now);
    k = 0;
    for (int i = now + 1; i <= 30; i++) begin
      @(negedge clk); if (bus_error === 1'b1 && k == 0) k = i;
    end
    check(k == 17, "R7 first ack keeps count", k, 17);
    start_win(2'b10, 0, 1, 1); now = 1; ack_at(5, now);
    hits = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (bus_error) hits++; end
    check(hits == 0, "R7 wide port single ack", hits, 0);

    // R8: select change mid-window
    cur_req = "R8";
    start_win(2'b11, 0, 0, 1);
    period_sel = 2'b00;
    measure(k, 12);
    check(k == 9, "R8 latched period", k, 9);
    idle(3);

    // R9: second strobe mid-window
    cur_req = "R9";
    start_win(2'b11, 0, 0, 1);
    idle(2); cycle_start = 1; @(negedge clk); cycle_start = 0;
    k = 0;
    for (int i = 5; i <= 14; i++) begin
      @(negedge clk); if (bus_error === 1'b1 && k == 0) k = i;
    end
    check(k == 9, "R9 no restart", k, 9);
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule